// File: doc/BRIEF.md
# Descriptor Chain DMA Controller with Resume

This block sequences a descriptor-chained DMA or XOR engine. Software writes the address of the first descriptor into a head register and sets a start bit. The controller reads the next-descriptor word stored at that address through a simple memory read port. It then hands the descriptor address to the data mover with a one-cycle go pulse, waits for the mover's done handshake, and moves on to the next descriptor. When the next-descriptor word is zero, the chain is finished. The controller clears Channel Active, sets End of Chain and pulses an interrupt.

Software may append descriptors after the engine has already read the last one. To do so it patches the old last descriptor's next-descriptor word and sets a resume bit. The controller merges the resume with its end-of-chain decision. It re-reads the next-descriptor word of the last descriptor and carries on. Channel Active stays high throughout, and no End of Chain is reported. A resume issued while the engine is idle after a finished chain restarts the re-read from the last descriptor. Moving the data itself is left to the mover behind the go/done handshake.

Top module: `dma_chain_ctrl`

## Requirements
- R1: After reset, CTRL and STATUS read zero, and mem_req, xfer_go and eoc_irq are low.
- R2: A start with a nonzero head runs through the chain. For each descriptor, the controller reads the word at the descriptor address as its next-descriptor address. It pulses xfer_go with xfer_desc equal to that descriptor address and waits for xfer_done. It then follows a nonzero next address. Descriptors run in link order.
- R3: When a next-descriptor word of zero is reached with no resume pending, Channel Active (STATUS bit 0) drops and End of Chain (STATUS bit 1) is set. eoc_irq is high for exactly one cycle, once per chain end.
- R4: A start with a head of zero sets End of Chain and pulses eoc_irq. No memory read and no transfer take place, and Channel Active never rises.
- R5: A start request while Channel Active is set is ignored, even if the head register has been changed.
- R6: A resume (CTRL bit 1) written while the chain runs is held and taken at the next next-address check. If the last next word was zero, the controller re-reads the last descriptor's next word. If that word is nonzero, it continues the chain with no eoc_irq, and Channel Active stays high without a gap.
- R7: If the re-read next word is zero and no further resume is pending, the chain ends as in R3, with a single eoc_irq.
- R8: A resume written while idle after a finished chain sets Channel Active and re-reads the next word of the last descriptor. It then continues from a nonzero address.
- R9: The resume bit clears itself once taken. A resume while idle with no previous chain (last descriptor address zero) is dropped without any memory read.
- R10: End of Chain is write-1-to-clear through STATUS bit 1. Writing 0 there leaves it unchanged, and a set in the same cycle wins.
- R11: Register offsets: 0 CTRL (bit 0 start, bit 1 resume), 1 STATUS (bit 0 Channel Active, bit 1 End of Chain), 2 HEAD (read/write), 3 CUR (current descriptor address, read-only), 4 NEXT (last next-descriptor word read, read-only). After a chain ends, CUR holds the last descriptor and NEXT reads zero.
- R12: A memory request holds mem_req and mem_addr stable until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register offset for read and write |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | ADDR_W | Descriptor address being read |
| mem_ack | input | 1 | Read data valid, completes the request |
| mem_rdata | input | ADDR_W | Next-descriptor word read |
| xfer_go | output | 1 | One-cycle pulse launching a descriptor on the mover |
| xfer_desc | output | ADDR_W | Address of the descriptor being executed |
| xfer_done | input | 1 | Mover finished the current descriptor |
| eoc_irq | output | 1 | One-cycle End of Chain interrupt |

## Verification
The chain function is driven with a plain three-descriptor chain, which confirms link-order traversal and a single end. It is also driven with an append-and-resume made after the last descriptor's next word was read but before its transfer finished. That case separates a merged resume from a spurious interrupt or a Channel Active gap. A resume with nothing appended checks that a zero re-read still ends the chain exactly once. A resume from idle after the end shows that the restart reads from the last descriptor and not from the head. A zero-head start, a start while running and a resume with no previous chain cover the inputs that must do nothing beyond their stated effect.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_DESC,
    ST_EXECUTE,
    ST_CHECK_NEXT,
    ST_RESUME_FETCH
  } dcc_state_e;

  localparam int unsigned REG_CTRL   = 0;
  localparam int unsigned REG_STATUS = 1;
  localparam int unsigned REG_HEAD   = 2;
  localparam int unsigned REG_CUR    = 3;
  localparam int unsigned REG_NEXT   = 4;

  localparam int unsigned CTRL_START_BIT  = 0;
  localparam int unsigned CTRL_RESUME_BIT = 1;
  localparam int unsigned STS_ACTIVE_BIT  = 0;
  localparam int unsigned STS_EOC_BIT     = 1;

endpackage

// File: rtl/dcc_regs.sv
module dcc_regs
  import dcc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              start_req,
  output logic              resume_pend,
  output logic [ADDR_W-1:0] head_addr,
  output logic              eoc_sts,
  input  logic              ev_eoc,
  input  logic              ev_resume_take,
  input  logic              ev_resume_drop,
  input  logic              chan_active,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] next_addr
);

  function automatic logic sel(input logic [REG_AW-1:0] a, input int unsigned idx);
    return (a == REG_AW'(idx));
  endfunction

  logic wr_ctrl, wr_status, wr_head;
  logic resume_set, eoc_clear;

  assign wr_ctrl    = reg_wr_en && sel(reg_addr, REG_CTRL);
  assign wr_status  = reg_wr_en && sel(reg_addr, REG_STATUS);
  assign wr_head    = reg_wr_en && sel(reg_addr, REG_HEAD);
  assign start_req  = wr_ctrl && reg_wdata[CTRL_START_BIT];
  assign resume_set = wr_ctrl && reg_wdata[CTRL_RESUME_BIT];
  assign eoc_clear  = wr_status && reg_wdata[STS_EOC_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resume_pend <= 1'b0;
      eoc_sts     <= 1'b0;
      head_addr   <= '0;
    end else begin
      if (resume_set)
        resume_pend <= 1'b1;
      else if (ev_resume_take || ev_resume_drop)
        resume_pend <= 1'b0;
      if (ev_eoc)
        eoc_sts <= 1'b1;
      else if (eoc_clear)
        eoc_sts <= 1'b0;
      if (wr_head)
        head_addr <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel(reg_addr, REG_CTRL)) begin
      reg_rdata[CTRL_RESUME_BIT] = resume_pend;
    end else if (sel(reg_addr, REG_STATUS)) begin
      reg_rdata[STS_ACTIVE_BIT] = chan_active;
      reg_rdata[STS_EOC_BIT]    = eoc_sts;
    end else if (sel(reg_addr, REG_HEAD)) begin
      reg_rdata = head_addr;
    end else if (sel(reg_addr, REG_CUR)) begin
      reg_rdata = cur_addr;
    end else if (sel(reg_addr, REG_NEXT)) begin
      reg_rdata = next_addr;
    end
  end

  // End of Chain set wins over a same-cycle clear (R10)
  assert_eoc_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_eoc) |-> eoc_sts);

  // A taken or dropped resume leaves the bit clear unless rewritten (R9)
  assert_resume_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(ev_resume_take) || $past(ev_resume_drop)) && !$past(resume_set)) |-> !resume_pend);

endmodule

// File: rtl/dcc_engine.sv
module dcc_engine
  import dcc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic              resume_pend,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              xfer_go,
  output logic [ADDR_W-1:0] xfer_desc,
  input  logic              xfer_done,
  output logic              chan_active,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] next_addr,
  output logic              ev_eoc,
  output logic              ev_resume_take,
  output logic              ev_resume_drop,
  output logic              eoc_irq
);

  function automatic logic is_null(input logic [ADDR_W-1:0] a);
    return (a == '0);
  endfunction

  dcc_state_e st;

  logic in_idle, in_check, in_refetch;
  logic ev_launch, ev_zero_start, idle_resume, idle_resume_go;
  logic check_take, refetch_zero, ev_chain_end;

  assign in_idle    = (st == ST_IDLE);
  assign in_check   = (st == ST_CHECK_NEXT);
  assign in_refetch = (st == ST_RESUME_FETCH);

  // Named events
  assign ev_launch      = in_idle && start_req && !is_null(head_addr);
  assign ev_zero_start  = in_idle && start_req && is_null(head_addr);
  assign idle_resume    = in_idle && !start_req && resume_pend;
  assign idle_resume_go = idle_resume && !is_null(cur_addr);
  assign ev_resume_drop = idle_resume && is_null(cur_addr);
  assign check_take     = in_check && resume_pend;
  assign refetch_zero   = in_refetch && mem_ack && is_null(mem_rdata);
  assign ev_resume_take = idle_resume_go || check_take || (refetch_zero && resume_pend);
  assign ev_chain_end   = (in_check && is_null(next_addr) && !resume_pend)
                        || (refetch_zero && !resume_pend);
  assign ev_eoc         = ev_chain_end || ev_zero_start;

  assign mem_req   = (st == ST_FETCH_DESC) || in_refetch;
  assign mem_addr  = cur_addr;
  assign xfer_desc = cur_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      cur_addr    <= '0;
      next_addr   <= '0;
      chan_active <= 1'b0;
      xfer_go     <= 1'b0;
      eoc_irq     <= 1'b0;
    end else begin
      xfer_go <= 1'b0;
      eoc_irq <= ev_eoc;
      case (st)
        ST_IDLE: begin
          if (ev_launch) begin
            cur_addr    <= head_addr;
            chan_active <= 1'b1;
            st          <= ST_FETCH_DESC;
          end else if (ev_zero_start) begin
            cur_addr  <= '0;
            next_addr <= '0;
          end else if (idle_resume_go) begin
            chan_active <= 1'b1;
            st          <= ST_RESUME_FETCH;
          end
        end
        ST_FETCH_DESC: begin
          if (mem_ack) begin
            next_addr <= mem_rdata;
            xfer_go   <= 1'b1;
            st        <= ST_EXECUTE;
          end
        end
        ST_EXECUTE: begin
          if (xfer_done) st <= ST_CHECK_NEXT;
        end
        ST_CHECK_NEXT: begin
          if (!is_null(next_addr)) begin
            cur_addr <= next_addr;
            st       <= ST_FETCH_DESC;
          end else if (resume_pend) begin
            st <= ST_RESUME_FETCH;
          end else begin
            chan_active <= 1'b0;
            st          <= ST_IDLE;
          end
        end
        ST_RESUME_FETCH: begin
          if (mem_ack) begin
            next_addr <= mem_rdata;
            if (!is_null(mem_rdata)) begin
              cur_addr <= mem_rdata;
              st       <= ST_FETCH_DESC;
            end else if (!resume_pend) begin
              chan_active <= 1'b0;
              st          <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_active_fall_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chan_active) |-> eoc_irq);

  assert_no_irq_while_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |-> !chan_active);

  assert_xfer_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |-> chan_active);

  // Channel Active rises only out of idle, never mid-chain (R5)
  assert_rise_from_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chan_active) |-> $past(in_idle));

  assert_drop_no_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_resume_drop |=> !mem_req);

endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
  import dcc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              xfer_go,
  output logic [ADDR_W-1:0] xfer_desc,
  input  logic              xfer_done,
  output logic              eoc_irq
);

  logic              start_req, resume_pend, eoc_sts, chan_active;
  logic              ev_eoc, ev_resume_take, ev_resume_drop;
  logic [ADDR_W-1:0] head_addr, cur_addr, next_addr;

  dcc_regs #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_wr_en      (reg_wr_en),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .start_req      (start_req),
    .resume_pend    (resume_pend),
    .head_addr      (head_addr),
    .eoc_sts        (eoc_sts),
    .ev_eoc         (ev_eoc),
    .ev_resume_take (ev_resume_take),
    .ev_resume_drop (ev_resume_drop),
    .chan_active    (chan_active),
    .cur_addr       (cur_addr),
    .next_addr      (next_addr)
  );

  dcc_engine #(.ADDR_W(ADDR_W)) u_engine (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_req      (start_req),
    .head_addr      (head_addr),
    .resume_pend    (resume_pend),
    .mem_req        (mem_req),
    .mem_addr       (mem_addr),
    .mem_ack        (mem_ack),
    .mem_rdata      (mem_rdata),
    .xfer_go        (xfer_go),
    .xfer_desc      (xfer_desc),
    .xfer_done      (xfer_done),
    .chan_active    (chan_active),
    .cur_addr       (cur_addr),
    .next_addr      (next_addr),
    .ev_eoc         (ev_eoc),
    .ev_resume_take (ev_resume_take),
    .ev_resume_drop (ev_resume_drop),
    .eoc_irq        (eoc_irq)
  );

  // The interrupt always coincides with a set End of Chain bit (R3)
  assert_irq_sets_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |-> eoc_sts);

endmodule

// File: tb/test_dma_chain_ctrl.sv
module test_dma_chain_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int RAW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [RAW-1:0] reg_addr = 3'd1;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic mem_req, mem_ack = 1'b0;
  logic [AW-1:0] mem_addr, mem_rdata = '0;
  logic xfer_go, xfer_done = 1'b0;
  logic [AW-1:0] xfer_desc;
  logic eoc_irq;

  dma_chain_ctrl #(.ADDR_W(AW), .REG_AW(RAW)) i_dma_chain_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .xfer_go(xfer_go), .xfer_desc(xfer_desc), .xfer_done(xfer_done),
    .eoc_irq(eoc_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  logic [AW-1:0] mem [256];
  logic [AW-1:0] xlog [64];
  int nlog = 0, xfer_cnt = 0, xfer_lat = 4;
  int irq_cnt = 0, irq_long = 0, rises = 0, falls = 0, req_cnt = 0;
  logic prev_act = 1'b0, prev_irq = 1'b0;

  // Memory and mover models, driven at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0; xfer_done = 1'b0; xfer_cnt = 0;
    end else begin
      if (mem_req && !mem_ack) begin
        mem_ack = 1'b1; mem_rdata = mem[mem_addr[7:0]];
      end else mem_ack = 1'b0;
      xfer_done = 1'b0;
      if (xfer_go) begin
        if (nlog < 64) xlog[nlog] = xfer_desc;
        nlog++;
        xfer_cnt = xfer_lat;
      end else if (xfer_cnt > 0) begin
        xfer_cnt--;
        if (xfer_cnt == 0) xfer_done = 1'b1;
      end
    end
  end

  // Port monitor, a quarter period after the rising edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n) begin
      if (eoc_irq) irq_cnt++;
      if (eoc_irq && prev_irq) irq_long++;
      prev_irq = eoc_irq;
      if (mem_req) req_cnt++;
      if (!reg_wr_en && reg_addr == 3'd1) begin
        if (reg_rdata[0] && !prev_act) rises++;
        if (!reg_rdata[0] && prev_act) falls++;
        prev_act = reg_rdata[0];
      end
    end
  end

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [RAW-1:0] a, input logic [AW-1:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_addr = 3'd1; reg_wdata = '0;
  endtask

  task automatic rd(input logic [RAW-1:0] a, output logic [AW-1:0] d);
    @(negedge clk);
    reg_addr = a; #1; d = reg_rdata; reg_addr = 3'd1;
  endtask

  task automatic wait_irq(input int target);
    for (int i = 0; i < 2000 && irq_cnt < target; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_log(input int target);
    for (int i = 0; i < 2000 && nlog < target; i++) @(negedge clk);
  endtask

  task automatic start_chain(input logic [AW-1:0] head);
    wr(3'd2, head);
    wr(3'd0, 32'h1);
  endtask

  task automatic t_reset;
    logic [AW-1:0] d;
    rd(3'd1, d); chk("R1 status", d, 0);
    rd(3'd0, d); chk("R1 ctrl", d, 0);
    chk("R1 outputs", {29'd0, mem_req, xfer_go, eoc_irq}, 0);
  endtask

  task automatic t_chain;
    logic [AW-1:0] d;
    int n0 = nlog, i0 = irq_cnt, f0 = falls;
    mem[8'h10] = 32'h20; mem[8'h20] = 32'h30; mem[8'h30] = 32'h0;
    start_chain(32'h10);
    wait_irq(i0 + 1);
    chk("R2 count", nlog - n0, 3);
    chk("R2 first", xlog[n0], 32'h10);
    chk("R2 second", xlog[n0+1], 32'h20);
    chk("R2 third", xlog[n0+2], 32'h30);
    chk("R3 irq once", irq_cnt - i0, 1);
    chk("R3 active fall", falls - f0, 1);
    rd(3'd1, d); chk("R3 status eoc", d, 32'h2);
    rd(3'd3, d); chk("R11 cur", d, 32'h30);
    rd(3'd4, d); chk("R11 next", d, 32'h0);
    rd(3'd2, d); chk("R11 head", d, 32'h10);
  endtask

  task automatic t_w1c;
    logic [AW-1:0] d;
    wr(3'd1, 32'h0);
    rd(3'd1, d); chk("R10 write 0 keeps", d, 32'h2);
    wr(3'd1, 32'h2);
    rd(3'd1, d); chk("R10 write 1 clears", d, 32'h0);
  endtask

  task automatic t_resume_idle;
    logic [AW-1:0] d;
    int n0 = nlog, i0 = irq_cnt, r0 = rises;
    mem[8'h30] = 32'h40; mem[8'h40] = 32'h0;
    wr(3'd0, 32'h2);
    wait_irq(i0 + 1);
    chk("R8 one new xfer", nlog - n0, 1);
    chk("R8 xfer from last link", xlog[n0], 32'h40);
    chk("R8 active rose", rises - r0, 1);
    rd(3'd0, d); chk("R9 resume self-clear", d, 32'h0);
    rd(3'd3, d); chk("R8 cur", d, 32'h40);
    wr(3'd1, 32'h2);
  endtask

  task automatic t_append_race;
    int n0 = nlog, i0 = irq_cnt, f0 = falls;
    xfer_lat = 20;
    mem[8'h50] = 32'h60; mem[8'h60] = 32'h0;
    start_chain(32'h50);
    wait_log(n0 + 2);
    repeat (3) @(negedge clk);
    chk("R6 no early irq", irq_cnt - i0, 0);
    mem[8'h60] = 32'h70; mem[8'h70] = 32'h0;
    wr(3'd0, 32'h2);
    wait_irq(i0 + 1);
    chk("R6 appended xfer count", nlog - n0, 3);
    chk("R6 appended desc", xlog[n0+2], 32'h70);
    chk("R6 single irq", irq_cnt - i0, 1);
    chk("R6 active no gap", falls - f0, 1);
    wr(3'd1, 32'h2);
  endtask

  task automatic t_resume_zero;
    logic [AW-1:0] d;
    int n0 = nlog, i0 = irq_cnt, f0 = falls;
    mem[8'h80] = 32'h0;
    start_chain(32'h80);
    wait_log(n0 + 1);
    wr(3'd0, 32'h2);
    wait_irq(i0 + 1);
    repeat (10) @(negedge clk);
    chk("R7 one xfer", nlog - n0, 1);
    chk("R7 one irq", irq_cnt - i0, 1);
    chk("R7 one fall", falls - f0, 1);
    rd(3'd0, d); chk("R9 resume cleared", d, 32'h0);
    xfer_lat = 4;
  endtask

  task automatic t_start_busy;
    int n0 = nlog, i0 = irq_cnt;
    xfer_lat = 20;
    mem[8'h90] = 32'hA0; mem[8'hA0] = 32'h0; mem[8'hB0] = 32'h0;
    start_chain(32'h90);
    wait_log(n0 + 1);
    start_chain(32'hB0);
    wait_irq(i0 + 1);
    repeat (10) @(negedge clk);
    chk("R5 xfer count", nlog - n0, 2);
    chk("R5 second desc", xlog[n0+1], 32'hA0);
    chk("R5 irq count", irq_cnt - i0, 1);
    xfer_lat = 4;
  endtask

  task automatic t_zero_head;
    logic [AW-1:0] d;
    int n0 = nlog, i0 = irq_cnt, r0 = rises, q0;
    wr(3'd1, 32'h2);
    q0 = req_cnt;
    start_chain(32'h0);
    repeat (5) @(negedge clk);
    chk("R4 irq", irq_cnt - i0, 1);
    chk("R4 no xfer", nlog - n0, 0);
    chk("R4 no read", req_cnt - q0, 0);
    chk("R4 no active", rises - r0, 0);
    rd(3'd1, d); chk("R4 eoc set", d, 32'h2);
    wr(3'd0, 32'h2);
    repeat (10) @(negedge clk);
    chk("R9 drop no read", req_cnt - q0, 0);
    rd(3'd0, d); chk("R9 drop clears", d, 32'h0);
    chk("R9 drop no irq", irq_cnt - i0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_chain();
    t_w1c();
    t_resume_idle();
    t_append_race();
    t_resume_zero();
    t_start_busy();
    t_zero_head();
    chk("R3 irq single cycle", irq_long, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule